// File: doc/BRIEF.md
# Segmented Address Translator

This block turns a two-part logical address into a physical address. The two parts are a segment number and an offset within that segment. A small table held inside the block describes each segment. An entry holds a physical start address, a length in bytes, a valid flag and three permission flags: read, write and execute. Two further registers hold the table origin and the number of segments in use. The origin register selects where the current program's descriptors start inside the table.

Configuration writes load entries and the two registers, as a context switch would. Translation requests use a valid/ready handshake. The block accepts one request per cycle and answers exactly one cycle later. The answer is either the relocated address or a fault with a cause code. When several problems occur in one request, a fixed priority picks the cause. Entries are independent of each other, so two descriptors may point at the same physical region with different lengths and rights.

Top module: `seg_xlate`

## Requirements
- R1: After reset, `rsp_valid`, `rsp_fault` and `rsp_pa` are 0. Every entry is invalid, and both the origin and the segment count are 0, so any request faults as out of range.
- R2: A request whose segment number is greater than or equal to the segment-count register faults with cause 1 (range).
- R3: The descriptor index is the origin plus the segment number. When that index is at or beyond the table depth, the request faults with cause 1, even if the segment number is below the segment count.
- R4: A request that selects an entry whose valid flag is 0 faults with cause 2 (invalid).
- R5: An offset greater than or equal to the entry's length faults with cause 3 (bounds).
- R6: The access type is encoded as 0 = read, 1 = write, 2 = execute and 3 = reserved. Each type needs its permission bit in the entry: bit 0 for read, bit 1 for write, bit 2 for execute. The reserved type always faults. A denied access faults with cause 4 (permission).
- R7: When several faults apply, the lowest cause number is reported (range, then invalid, then bounds, then permission). `rsp_fault` is 1 exactly when the cause is not 0.
- R8: A request with no fault returns `rsp_fault` = 0, cause 0, and an address equal to the entry base plus the offset, modulo 2^PA_W.
- R9: On a fault, `rsp_pa` is 0.
- R10: `req_ready` is always 1. `rsp_valid` is high in exactly the cycle after each accepted request, and low otherwise.
- R11: A configuration write in the same cycle as an accepted request does not change that request's result. Requests accepted afterwards see the new value.
- R12: Entries that share a base are translated independently, each with its own length and permissions.
- R13: The entry used is the one at the origin plus the segment number, not the one at the segment number alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_seg | input | SEG_W | Segment number |
| req_off | input | OFF_W | Offset within segment |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Write target: 0 entry, 1 origin register, 2 segment-count register, 3 none |
| cfg_idx | input | AW | Entry index for entry writes; new origin for origin writes |
| cfg_base | input | PA_W | Entry physical base |
| cfg_limit | input | OFF_W+1 | Entry length |
| cfg_perm | input | 3 | Entry permissions (bit 0 read, bit 1 write, bit 2 execute) |
| cfg_valid | input | 1 | Entry valid flag |
| cfg_len | input | SEG_W+1 | New segment count |
| rsp_valid | output | 1 | Response present |
| rsp_pa | output | PA_W | Physical address, 0 on fault |
| rsp_fault | output | 1 | Request faulted |
| rsp_cause | output | 3 | 0 none, 1 range, 2 invalid, 3 bounds, 4 permission |

## Verification
The bench first requests an empty table, and then a table that mixes full-rights entries, read-only entries, execute-only entries and an invalid entry. It probes offsets just below and exactly at each length, which separates an off-by-one bound from a correct one. Some requests break several rules at once, which shows whether the cause priority is kept. A nonzero origin combined with an index that runs past the table depth separates relocation through the origin from direct indexing. A base near the top of the address space shows that addresses wrap. A request issued in the same cycle as a rewrite of its own entry shows whether the table is sampled at acceptance time.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_EXEC  = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_e;

   typedef enum logic [2:0] {
      CZ_NONE      = 3'd0,
      CZ_SEG_RANGE = 3'd1,
      CZ_INVALID   = 3'd2,
      CZ_BOUNDS    = 3'd3,
      CZ_PERM      = 3'd4
   } cause_e;

   typedef enum logic [1:0] {
      CFG_ENTRY = 2'd0,
      CFG_TBASE = 2'd1,
      CFG_TLEN  = 2'd2,
      CFG_NOP   = 2'd3
   } cfg_e;

   localparam int PERM_R = 0;
   localparam int PERM_W = 1;
   localparam int PERM_X = 2;
endpackage

// File: rtl/seg_xlate_table.sv
module seg_xlate_table
   import seg_xlate_pkg::*;
#(
   parameter int SEG_W = 4,
   parameter int OFF_W = 12,
   parameter int PA_W  = 16,
   parameter int DEPTH = 16,
   parameter int AW    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [1:0]       cfg_kind,
   input  logic [AW-1:0]    cfg_idx,
   input  logic [PA_W-1:0]  cfg_base,
   input  logic [OFF_W:0]   cfg_limit,
   input  logic [2:0]       cfg_perm,
   input  logic             cfg_valid,
   input  logic [SEG_W:0]   cfg_len,
   input  logic [AW-1:0]    rd_idx,
   output logic [PA_W-1:0]  rd_base,
   output logic [OFF_W:0]   rd_limit,
   output logic [2:0]       rd_perm,
   output logic             rd_valid,
   output logic [AW-1:0]    tbase,
   output logic [SEG_W:0]   tlen
);
   logic [PA_W-1:0] e_base  [DEPTH];
   logic [OFF_W:0]  e_limit [DEPTH];
   logic [2:0]      e_perm  [DEPTH];
   logic [DEPTH-1:0] e_valid;

   logic wr_entry, wr_tbase, wr_tlen;
   assign wr_entry = cfg_we && (cfg_e'(cfg_kind) == CFG_ENTRY);
   assign wr_tbase = cfg_we && (cfg_e'(cfg_kind) == CFG_TBASE);
   assign wr_tlen  = cfg_we && (cfg_e'(cfg_kind) == CFG_TLEN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            e_base[i]  <= '0;
            e_limit[i] <= '0;
            e_perm[i]  <= '0;
         end
         e_valid <= '0;
      end else if (wr_entry) begin
         for (int i = 0; i < DEPTH; i++) begin
            if (cfg_idx == AW'(i)) begin
               e_base[i]  <= cfg_base;
               e_limit[i] <= cfg_limit;
               e_perm[i]  <= cfg_perm;
               e_valid[i] <= cfg_valid;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tbase <= '0;
         tlen  <= '0;
      end else begin
         if (wr_tbase) tbase <= cfg_idx;
         if (wr_tlen)  tlen  <= cfg_len;
      end
   end

   // read mux: indexes that name no entry return an all-zero descriptor
   always_comb begin
      rd_base  = '0;
      rd_limit = '0;
      rd_perm  = '0;
      rd_valid = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
         if (rd_idx == AW'(i)) begin
            rd_base  = e_base[i];
            rd_limit = e_limit[i];
            rd_perm  = e_perm[i];
            rd_valid = e_valid[i];
         end
      end
   end

   // R1: an entry-kind write never changes the origin register
   a_r1_tbase_only_by_kind: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_e'(cfg_kind) != CFG_TBASE) |=> $stable(tbase));
endmodule

// File: rtl/seg_xlate_check.sv
module seg_xlate_check
   import seg_xlate_pkg::*;
#(
   parameter int SEG_W = 4,
   parameter int OFF_W = 12,
   parameter int PA_W  = 16,
   parameter int DEPTH = 16,
   parameter int AW    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEG_W-1:0] seg,
   input  logic [OFF_W-1:0] off,
   input  logic [1:0]       acc,
   input  logic [AW-1:0]    tbase,
   input  logic [SEG_W:0]   tlen,
   input  logic [PA_W-1:0]  rd_base,
   input  logic [OFF_W:0]   rd_limit,
   input  logic [2:0]       rd_perm,
   input  logic             rd_valid,
   output logic [AW-1:0]    rd_idx,
   output logic             fault,
   output logic [2:0]       cause,
   output logic [PA_W-1:0]  pa
);
   localparam int IW = ((AW > SEG_W) ? AW : SEG_W) + 1;

   logic [IW-1:0] idx_wide;
   logic seg_bad, idx_bad, bnd_bad, perm_ok;
   cause_e cz;

   assign idx_wide = IW'(tbase) + IW'(seg);
   assign rd_idx   = idx_wide[AW-1:0];
   assign seg_bad  = ((SEG_W+1)'(seg) >= tlen);
   assign idx_bad  = (idx_wide >= IW'(DEPTH));
   assign bnd_bad  = ((OFF_W+1)'(off) >= rd_limit);

   always_comb begin
      unique case (acc_e'(acc))
         ACC_READ:  perm_ok = rd_perm[PERM_R];
         ACC_WRITE: perm_ok = rd_perm[PERM_W];
         ACC_EXEC:  perm_ok = rd_perm[PERM_X];
         default:   perm_ok = 1'b0;
      endcase
   end

   always_comb begin
      if (seg_bad || idx_bad) cz = CZ_SEG_RANGE;
      else if (!rd_valid)     cz = CZ_INVALID;
      else if (bnd_bad)       cz = CZ_BOUNDS;
      else if (!perm_ok)      cz = CZ_PERM;
      else                    cz = CZ_NONE;
   end

   assign cause = cz;
   assign fault = (cz != CZ_NONE);
   assign pa    = fault ? '0 : (rd_base + PA_W'(off));

   // R2: a segment number at or past the count is always reported as range
   a_r2_seg_range: assert property (@(posedge clk) disable iff (!rst_n)
      ((SEG_W+1)'(seg) >= tlen) |-> (cause == CZ_SEG_RANGE));

   // R4: an invalid descriptor is reported unless the range check already fired
   a_r4_invalid: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_valid && cause != CZ_SEG_RANGE) |-> (cause == CZ_INVALID));
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
   import seg_xlate_pkg::*;
#(
   parameter int SEG_W = 4,
   parameter int OFF_W = 12,
   parameter int PA_W  = 16,
   parameter int DEPTH = 16,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [SEG_W-1:0] req_seg,
   input  logic [OFF_W-1:0] req_off,
   input  logic [1:0]       req_acc,
   input  logic             cfg_we,
   input  logic [1:0]       cfg_kind,
   input  logic [AW-1:0]    cfg_idx,
   input  logic [PA_W-1:0]  cfg_base,
   input  logic [OFF_W:0]   cfg_limit,
   input  logic [2:0]       cfg_perm,
   input  logic             cfg_valid,
   input  logic [SEG_W:0]   cfg_len,
   output logic             rsp_valid,
   output logic [PA_W-1:0]  rsp_pa,
   output logic             rsp_fault,
   output logic [2:0]       rsp_cause
);
   if (PA_W < OFF_W) begin : g_bad_pa_w
      $error("seg_xlate: PA_W must be at least OFF_W");
   end
   if (SEG_W < 1 || OFF_W < 1) begin : g_bad_fields
      $error("seg_xlate: field widths must be positive");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("seg_xlate: DEPTH must be at least 2");
   end

   logic [AW-1:0]   rd_idx, tbase;
   logic [SEG_W:0]  tlen;
   logic [PA_W-1:0] rd_base, c_pa;
   logic [OFF_W:0]  rd_limit;
   logic [2:0]      rd_perm, c_cause;
   logic            rd_valid, c_fault;

   assign req_ready = 1'b1;

   seg_xlate_table #(
      .SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W), .DEPTH(DEPTH), .AW(AW)
   ) u_table (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_idx(cfg_idx),
      .cfg_base(cfg_base), .cfg_limit(cfg_limit), .cfg_perm(cfg_perm),
      .cfg_valid(cfg_valid), .cfg_len(cfg_len),
      .rd_idx(rd_idx), .rd_base(rd_base), .rd_limit(rd_limit),
      .rd_perm(rd_perm), .rd_valid(rd_valid),
      .tbase(tbase), .tlen(tlen)
   );

   seg_xlate_check #(
      .SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W), .DEPTH(DEPTH), .AW(AW)
   ) u_check (
      .clk(clk), .rst_n(rst_n),
      .seg(req_seg), .off(req_off), .acc(req_acc),
      .tbase(tbase), .tlen(tlen),
      .rd_base(rd_base), .rd_limit(rd_limit), .rd_perm(rd_perm), .rd_valid(rd_valid),
      .rd_idx(rd_idx), .fault(c_fault), .cause(c_cause), .pa(c_pa)
   );

   // result is captured from the table contents before any same-edge config write lands
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_pa    <= '0;
         rsp_fault <= 1'b0;
         rsp_cause <= CZ_NONE;
      end else begin
         rsp_valid <= req_valid && req_ready;
         if (req_valid && req_ready) begin
            rsp_pa    <= c_pa;
            rsp_fault <= c_fault;
            rsp_cause <= c_cause;
         end
      end
   end

   // R10: one response, exactly one cycle after each accepted request
   a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> rsp_valid);
   a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   // R9: a faulted response carries a zero address
   a_r9_fault_zero_pa: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault) |-> (rsp_pa == '0));
   // R7: fault flag and cause code agree
   a_r7_cause_agrees: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_fault == (rsp_cause != 3'd0)));
endmodule

// File: tb/seg_xlate_test.sv
`timescale 1ns/1ps
module seg_xlate_test;
   localparam int SEG_W = 4, OFF_W = 12, PA_W = 16, DEPTH = 16, AW = 4;

   logic clk = 0, rst_n = 0;
   logic req_valid = 0, req_ready;
   logic [SEG_W-1:0] req_seg = '0;
   logic [OFF_W-1:0] req_off = '0;
   logic [1:0] req_acc = '0;
   logic cfg_we = 0;
   logic [1:0] cfg_kind = '0;
   logic [AW-1:0] cfg_idx = '0;
   logic [PA_W-1:0] cfg_base = '0;
   logic [OFF_W:0] cfg_limit = '0;
   logic [2:0] cfg_perm = '0;
   logic cfg_valid = 0;
   logic [SEG_W:0] cfg_len = '0;
   logic rsp_valid, rsp_fault;
   logic [PA_W-1:0] rsp_pa;
   logic [2:0] rsp_cause;

   always #4 clk = ~clk;

   seg_xlate #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W), .DEPTH(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_seg(req_seg), .req_off(req_off), .req_acc(req_acc),
      .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_idx(cfg_idx), .cfg_base(cfg_base),
      .cfg_limit(cfg_limit), .cfg_perm(cfg_perm), .cfg_valid(cfg_valid), .cfg_len(cfg_len),
      .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause)
   );

   int total = 0, bad = 0, cyc = 0;
   bit done = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // bench-side model of the table
   int m_base[DEPTH], m_lim[DEPTH], m_perm[DEPTH];
   bit m_val[DEPTH];
   int m_tbase = 0, m_tlen = 0;

   // scoreboard
   int q_pa[$], q_cause[$], q_cyc[$];
   string q_tag[$];

   task automatic check(bit ok, string tag, string what, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
      req_valid = 0;
      cfg_we = 0;
   endtask

   task automatic req(int s, int d, int acc, string tag);
      int idx, cz, pa;
      bit ok;
      idx = m_tbase + s;
      cz = 0;
      if (s >= m_tlen || idx >= DEPTH) cz = 1;
      else if (!m_val[idx]) cz = 2;
      else if (d >= m_lim[idx]) cz = 3;
      else begin
         ok = (acc == 0) ? m_perm[idx][0] : (acc == 1) ? m_perm[idx][1] :
              (acc == 2) ? m_perm[idx][2] : 1'b0;
         if (!ok) cz = 4;
      end
      pa = (cz == 0) ? ((m_base[idx] + d) & 32'hFFFF) : 0;
      q_pa.push_back(pa); q_cause.push_back(cz); q_cyc.push_back(cyc); q_tag.push_back(tag);
      req_valid = 1; req_seg = SEG_W'(s); req_off = OFF_W'(d); req_acc = 2'(acc);
   endtask

   task automatic cfg_entry(int idx, int base, int lim, int perm, bit v);
      cfg_we = 1; cfg_kind = 2'd0; cfg_idx = AW'(idx); cfg_base = PA_W'(base);
      cfg_limit = (OFF_W+1)'(lim); cfg_perm = 3'(perm); cfg_valid = v;
      m_base[idx] = base; m_lim[idx] = lim; m_perm[idx] = perm; m_val[idx] = v;
   endtask

   task automatic cfg_tbase(int v);
      cfg_we = 1; cfg_kind = 2'd1; cfg_idx = AW'(v); m_tbase = v;
   endtask

   task automatic cfg_tlen(int v);
      cfg_we = 1; cfg_kind = 2'd2; cfg_len = (SEG_W+1)'(v); m_tlen = v;
   endtask

   // monitor
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (q_pa.size() == 0) begin
            check(0, "R10", "unexpected response", 1, 0);
         end else begin
            int epa, ecz, ecy;
            string tg;
            epa = q_pa.pop_front(); ecz = q_cause.pop_front();
            ecy = q_cyc.pop_front(); tg = q_tag.pop_front();
            check(cyc == ecy + 1, "R10", "latency", cyc - ecy, 1);
            check(int'(rsp_cause) == ecz, tg, "cause", int'(rsp_cause), ecz);
            check(int'(rsp_fault) == (ecz != 0 ? 1 : 0), tg, "fault", int'(rsp_fault), ecz != 0);
            check(int'(rsp_pa) == epa, tg, "pa", int'(rsp_pa), epa);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL R10 watchdog actual=hung expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) begin
         m_base[i] = 0; m_lim[i] = 0; m_perm[i] = 0; m_val[i] = 0;
      end
      repeat (3) @(negedge clk);
      // R1: reset state
      check(rsp_valid == 0, "R1", "rsp_valid in reset", int'(rsp_valid), 0);
      check(rsp_fault == 0, "R1", "rsp_fault in reset", int'(rsp_fault), 0);
      check(rsp_pa == 0, "R1", "rsp_pa in reset", int'(rsp_pa), 0);
      check(req_ready == 1, "R10", "req_ready", int'(req_ready), 1);
      rst_n = 1;
      step(); req(0, 0, 0, "R1");
      step(); req(5, 3, 1, "R1");
      // load table
      step(); cfg_tlen(8);
      step(); cfg_entry(0, 'h1000, 'h100, 3'b111, 1);
      step(); cfg_entry(1, 'h1000, 'h40, 3'b001, 1);
      step(); cfg_entry(2, 'h4000, 'h800, 3'b111, 0);
      step(); cfg_entry(3, 'hFF00, 'h1000, 3'b100, 1);
      step(); cfg_entry(15, 'h2000, 'h800, 3'b011, 1);
      // main function, back to back
      step(); req(0, 'h20, 0, "R8");
      step(); req(0, 'hFF, 1, "R5");
      step(); req(0, 'h100, 0, "R5");
      step(); req(0, 'h50, 1, "R12");
      step(); req(1, 'h10, 1, "R12");
      step(); req(1, 'h10, 0, "R12");
      step(); req(1, 'h3F, 2, "R6");
      step(); req(1, 'h50, 1, "R7");
      step(); req(2, 'h10, 0, "R4");
      step(); req(2, 'hFFF, 3, "R7");
      step(); req(8, 0, 0, "R2");
      step(); req(7, 0, 0, "R2");
      step(); req(0, 0, 3, "R6");
      step(); req(3, 'h200, 2, "R8");
      step(); req(3, 'hFFF, 2, "R8");
      step(); req(3, 'h10, 0, "R6");
      step(); req(9, 'hFFF, 1, "R7");
      // idle cycles: no response expected
      step(); step(); step();
      // relocation through origin register
      step(); cfg_tbase(12);
      step(); cfg_tlen(16);
      step(); req(3, 5, 0, "R13");
      step(); req(3, 5, 1, "R13");
      step(); req(3, 5, 2, "R6");
      step(); req(4, 0, 0, "R3");
      step(); req(0, 0, 0, "R13");
      // in-flight write: same-cycle update must not affect this request
      step(); req(3, 5, 0, "R11"); cfg_entry(15, 'h3000, 'h800, 3'b001, 1);
      step(); req(3, 5, 0, "R11");
      step(); req(3, 5, 1, "R11");
      step(); cfg_tlen(3);
      step(); req(3, 5, 0, "R11");
      step(); step(); step();
      check(q_pa.size() == 0, "R10", "responses outstanding", q_pa.size(), 0);
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule